// File: doc/BRIEF.md
# Rewindable FIFO with Half-Full Flag

A single-clock first-in/first-out buffer for 9-bit words. The producer presents a word with a one-cycle write request. The consumer issues one-cycle read requests and receives each word one cycle later, marked by a valid strobe. Three active-low status outputs report the state of the buffer: empty, full, and more-than-half-full. A write is accepted only while the buffer is not full, and a read only while it is not empty. A refused request changes nothing inside the block. The ninth data bit has no special meaning and passes through unchanged, so the user can carry parity or a control marker in it.

A rewind input moves the read position back to storage location zero and leaves the write position where it is. Data already consumed can then be read a second time. After a rewind the occupancy becomes the number of writes since reset, capped at the depth, and the three flags are recomputed from that value. The depth is a power-of-two parameter and the storage is written so that block RAM can be inferred.

Top module: `rewind_fifo`

## Requirements
- R1: While `rst` is high, and on the first falling edge after it is released, `empty_n` is 0, `full_n` is 1, `half_n` is 1 and `rd_valid` is 0. Both positions are at location zero.
- R2: Words are read out in the order they were written, and all 9 bits arrive unchanged. This includes bit 8.
- R3: A write request while `full_n` is 0 is ignored. Stored data and the write position are unchanged, so the buffer stays full and later reads return only the words accepted earlier.
- R4: A read request while `empty_n` is 0 is ignored. `rd_valid` stays 0 and the read position does not move.
- R5: `empty_n` is 0 exactly when the occupancy is 0. `full_n` is 0 exactly when the occupancy equals DEPTH, which is reached after DEPTH accepted writes with no reads. The two are never low together.
- R6: `half_n` is 0 exactly when the occupancy is greater than DEPTH/2. It can only fall after a write or rewind, and it can only rise after a read or rewind.
- R7: A one-cycle `rewind` pulse sets the read position to location zero and keeps the write position. The occupancy becomes the count of writes since reset, capped at DEPTH. Flags follow that value on the next cycle, and the reads that follow return data starting at location zero.
- R8: Read and write requests that coincide with `rewind` are ignored.
- R9: `rd_valid` is 1 for exactly one cycle, the cycle after an accepted read, and `rd_data` holds the read word in that cycle.
- R10: An accepted read and an accepted write in the same cycle leave the occupancy, and therefore the flags, unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Write request, one word per cycle |
| wr_data | input | 9 | Word to store |
| rd_req | input | 1 | Read request, one word per cycle |
| rewind | input | 1 | Move the read position back to location zero |
| rd_data | output | 9 | Word returned by an accepted read |
| rd_valid | output | 1 | High in the cycle `rd_data` carries a read word |
| empty_n | output | 1 | Low when no unread word is stored |
| full_n | output | 1 | Low when DEPTH words are stored |
| half_n | output | 1 | Low when more than DEPTH/2 words are stored |

## Verification
The properties assume that `rst` has a known high value from time zero and that every input is a clean level sampled at the rising edge. They also assume DEPTH is a power of two of at least 4, so empty and full cannot coincide. They do not rely on the requests being idle during a rewind: that rule is honoured by gating inside the block, and one property checks that no read completes after a rewind cycle. The stimulus changes inputs only on falling edges, holds reset from the start, and deliberately raises both requests during a rewind so that the gating is exercised.

// File: rtl/rewind_fifo_pkg.sv
`timescale 1ns/1ps
package rewind_fifo_pkg;
  // Active-low status bundle produced by the flag stage.
  typedef struct packed {
    logic empty_n;
    logic full_n;
    logic half_n;
  } fifo_flags_t;
endpackage

// File: rtl/rewind_fifo_mem.sv
`timescale 1ns/1ps
// Simple dual-port storage with a registered read, written for RAM inference.
module rewind_fifo_mem #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [WIDTH-1:0]         wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [WIDTH-1:0]         rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/rewind_fifo_ctrl.sv
`timescale 1ns/1ps
// Position counters, occupancy and the saturating count of writes since reset.
module rewind_fifo_ctrl #(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_req,
  input  logic                     rd_req,
  input  logic                     rewind,
  input  logic                     full_n,
  input  logic                     empty_n,
  output logic                     wr_ok,
  output logic                     rd_ok,
  output logic [$clog2(DEPTH)-1:0] wr_ptr,
  output logic [$clog2(DEPTH)-1:0] rd_ptr,
  output logic [$clog2(DEPTH):0]   occ_nxt
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0] occ;
  logic [CW-1:0] wr_seen;

  // Requests that coincide with a rewind are dropped (R8).
  assign wr_ok = wr_req & full_n  & ~rewind;
  assign rd_ok = rd_req & empty_n & ~rewind;

  always_comb begin
    if (rewind) begin
      occ_nxt = wr_seen;                      // R7
    end else begin
      unique case ({wr_ok, rd_ok})
        2'b10:   occ_nxt = occ + CW'(1);
        2'b01:   occ_nxt = occ - CW'(1);
        default: occ_nxt = occ;               // R10: both or neither
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ     <= '0;
      wr_seen <= '0;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
    end else begin
      occ <= occ_nxt;
      if (wr_ok) begin
        wr_ptr <= wr_ptr + AW'(1);
        if (wr_seen != FULL_CNT) wr_seen <= wr_seen + CW'(1);
      end
      if (rewind)     rd_ptr <= '0;
      else if (rd_ok) rd_ptr <= rd_ptr + AW'(1);
    end
  end
endmodule

// File: rtl/rewind_fifo_flags.sv
`timescale 1ns/1ps
// Registers the three active-low flags from the next-cycle occupancy.
module rewind_fifo_flags
  import rewind_fifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [$clog2(DEPTH):0] occ_nxt,
  output fifo_flags_t            flags
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags.empty_n <= 1'b0;
      flags.full_n  <= 1'b1;
      flags.half_n  <= 1'b1;
    end else begin
      flags.empty_n <= (occ_nxt != '0);
      flags.full_n  <= (occ_nxt != FULL_CNT);
      flags.half_n  <= ~(occ_nxt > HALF_CNT);
    end
  end
endmodule

// File: rtl/rewind_fifo.sv
`timescale 1ns/1ps
module rewind_fifo
  import rewind_fifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  input  logic              rewind,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              empty_n,
  output logic              full_n,
  output logic              half_n
);
  localparam int AW = $clog2(DEPTH);

  logic          wr_ok, rd_ok;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   occ_nxt;
  fifo_flags_t   flags;

  rewind_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr_req (wr_req),
    .rd_req (rd_req),
    .rewind (rewind),
    .full_n (flags.full_n),
    .empty_n(flags.empty_n),
    .wr_ok  (wr_ok),
    .rd_ok  (rd_ok),
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .occ_nxt(occ_nxt)
  );

  rewind_fifo_flags #(.DEPTH(DEPTH)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .occ_nxt(occ_nxt),
    .flags  (flags)
  );

  rewind_fifo_mem #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk  (clk),
    .we   (wr_ok),
    .waddr(wr_ptr),
    .wdata(wr_data),
    .re   (rd_ok),
    .raddr(rd_ptr),
    .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= rd_ok;               // R9
  end

  assign empty_n = flags.empty_n;
  assign full_n  = flags.full_n;
  assign half_n  = flags.half_n;
endmodule

// File: rtl/rewind_fifo_chk.sv
`timescale 1ns/1ps
module rewind_fifo_chk (
  input logic clk,
  input logic rst,
  input logic wr_req,
  input logic rd_req,
  input logic rewind,
  input logic rd_valid,
  input logic empty_n,
  input logic full_n,
  input logic half_n
);
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) && !rst |-> !empty_n && full_n && half_n && !rd_valid);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    !full_n && wr_req && !rd_req && !rewind |=> !full_n);

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    !empty_n && rd_req |=> !rd_valid);

  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(!empty_n && !full_n));

  assert_half_fall_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(half_n) |-> $past(wr_req || rewind));

  assert_half_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(half_n) |-> $past(rd_req || rewind));

  assert_rewind_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    rewind |=> !rd_valid);

  assert_valid_source_R9: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_req && empty_n && !rewind));
endmodule

bind rewind_fifo rewind_fifo_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_req  (wr_req),
  .rd_req  (rd_req),
  .rewind  (rewind),
  .rd_valid(rd_valid),
  .empty_n (empty_n),
  .full_n  (full_n),
  .half_n  (half_n)
);

// File: tb/rewind_fifo_tb.sv
`timescale 1ns/1ps
module rewind_fifo_tb;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_req = 1'b0, rd_req = 1'b0, rewind = 1'b0;
  logic [8:0] wr_data = '0;
  logic [8:0] rd_data;
  logic       rd_valid, empty_n, full_n, half_n;

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference state built from the requirements.
  logic [8:0] m_mem [DEPTH];
  int m_wp, m_rp, m_cnt, m_seen;

  always #2.5 clk = ~clk;

  rewind_fifo #(.DATA_W(9), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_data(wr_data),
    .rd_req(rd_req), .rewind(rewind), .rd_data(rd_data),
    .rd_valid(rd_valid), .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_flags(input string tag);
    chk(empty_n === (m_cnt != 0), tag, "empty_n", int'(empty_n), int'(m_cnt != 0));
    chk(full_n === (m_cnt != DEPTH), tag, "full_n", int'(full_n), int'(m_cnt != DEPTH));
    chk(half_n === (m_cnt <= DEPTH/2), tag, "half_n", int'(half_n), int'(m_cnt <= DEPTH/2));
  endtask

  // One clock of stimulus; outputs are compared on the following falling edge.
  task automatic step(input logic w, input logic r, input logic t,
                      input logic [8:0] d, input string tag);
    logic wa, ra;
    logic [8:0] ed;
    wr_req = w; rd_req = r; rewind = t; wr_data = d;
    wa = w && (m_cnt != DEPTH) && !t;
    ra = r && (m_cnt != 0) && !t;
    ed = m_mem[m_rp];
    if (wa) begin
      m_mem[m_wp] = d;
      m_wp = (m_wp + 1) % DEPTH;
      if (m_seen < DEPTH) m_seen++;
    end
    if (t) begin
      m_rp = 0;
      m_cnt = m_seen;
    end else begin
      if (ra) m_rp = (m_rp + 1) % DEPTH;
      m_cnt = m_cnt + (wa ? 1 : 0) - (ra ? 1 : 0);
    end
    @(posedge clk);
    @(negedge clk);
    wr_req = 0; rd_req = 0; rewind = 0;
    chk(rd_valid === ra, tag, "rd_valid", int'(rd_valid), int'(ra));
    if (ra) chk(rd_data === ed, tag, "rd_data", int'(rd_data), int'(ed));
    check_flags(tag);
  endtask

  task automatic t_reset();
    rst = 1; wr_req = 0; rd_req = 0; rewind = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(!empty_n && full_n && half_n, "R1", "flags",
        int'({empty_n, full_n, half_n}), 3'b011);
    rst = 0;
    m_wp = 0; m_rp = 0; m_cnt = 0; m_seen = 0;
    @(negedge clk);
    chk(rd_valid === 1'b0, "R1", "rd_valid", int'(rd_valid), 0);
    check_flags("R1");
  endtask

  task automatic t_fill_to_full();
    for (int i = 0; i < DEPTH; i++)
      step(1, 0, 0, 9'((i * 37) ^ ((i % 2) << 8)), "R5 R6");
    step(1, 0, 0, 9'h1AA, "R3");
    step(1, 0, 0, 9'h055, "R3");
    step(1, 1, 0, 9'h0F0, "R3 R9");  // read taken, write refused at full
    step(1, 0, 0, 9'h123, "R5");     // one slot free: accepted
  endtask

  task automatic t_drain();
    for (int i = 0; i < DEPTH; i++) step(0, 1, 0, '0, "R2 R9 R6");
    step(0, 1, 0, '0, "R4");
    step(0, 1, 0, '0, "R4");
  endtask

  task automatic t_simultaneous();
    for (int i = 0; i < 3; i++) step(1, 0, 0, 9'(9'h100 + i), "R2");
    for (int i = 0; i < 6; i++) step(1, 1, 0, 9'(9'h0C0 + i * 5), "R10");
    step(1, 1, 0, 9'h1FF, "R10");
    for (int i = 0; i < 4; i++) step(0, 1, 0, '0, "R2");
    step(0, 1, 0, '0, "R4");
  endtask

  task automatic t_partial_retransmit();
    t_reset();
    for (int i = 0; i < 5; i++) step(1, 0, 0, 9'(9'h150 ^ (i * 9)), "R2");
    for (int i = 0; i < 3; i++) step(0, 1, 0, '0, "R2");
    step(1, 1, 1, 9'h0EE, "R8 R7");
    for (int i = 0; i < 5; i++) step(0, 1, 0, '0, "R7");
    step(0, 1, 0, '0, "R4");
  endtask

  task automatic t_wrap_retransmit();
    t_reset();
    for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 9'(i * 11), "R5");
    for (int i = 0; i < 4; i++) step(0, 1, 0, '0, "R6");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 9'(9'h1E0 + i), "R6");
    step(0, 0, 1, '0, "R7");
    for (int i = 0; i < DEPTH; i++) step(0, 1, 0, '0, "R7");
    step(0, 1, 0, '0, "R4");
  endtask

  initial begin
    t_reset();
    t_fill_to_full();
    t_drain();
    t_simultaneous();
    t_partial_retransmit();
    t_wrap_retransmit();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule